// File: doc/BRIEF.md
# Clock Failure Monitor with Fallback Switch

This block watches an external clock from a free-running reference clock. Each input-clock transition is carried into the reference domain through a synchronizer. A counter measures how many reference cycles pass between transitions. If the gap reaches a programmable limit, the input clock is treated as missing or unstable.

The block has two configurations, chosen by a pin while reset is asserted.

- **Direct-drive configuration:** a detected failure moves the system clock to an always-running fallback clock. The move goes through a glitch-free two-source switch. The block stays on the fallback clock until the next reset. An enable pin, held low, turns this monitoring off.
- **PLL configuration:** the clock source is never changed. Instead, a falling lock indication from the external PLL is reported.

Both kinds of event set one shared interrupt request flag. Hardware sets the flag, and software clears it by writing 0. The flag has its own power-on reset, so it keeps working while the system reset is asserted. This means a lock loss during reset is still recorded.

Top module: `clk_fail_guard`

## Requirements
- R1: The configuration is sampled from `cfg_pll_mode` on every reference edge while `rst_n` is low (1 = PLL configuration, 0 = direct drive). After `rst_n` goes high it is held, and later changes of the pin are ignored.
- R2: In direct drive with monitoring enabled, the fallback is selected if `win_len` consecutive reference cycles pass with no synchronized transition of `ext_clk`. The fallback is `clk_sel` = 1, with `sys_clk` taken from `fb_clk`. `win_len` must be at least 4. This covers both a stopped clock and one that is too slow.
- R3: With `wd_en` low, no failure is detected. `clk_sel` stays 0 and the flag stays unchanged, even when `ext_clk` is stopped.
- R4: Once `clk_sel` is 1, it stays 1 until `rst_n` is asserted, even if `ext_clk` resumes.
- R5: The cycle in which a direct-drive failure is first detected sets `irq_flag`. The next reference edge after that cycle shows `irq_flag` = 1.
- R6: In the PLL configuration, a synchronized 1-to-0 change of `pll_locked` sets `irq_flag`. The input clock is not monitored in this configuration, and `clk_sel` stays 0.
- R7: `irq_flag` is cleared only by `por_n`. A lock loss in the PLL configuration while `rst_n` is low still sets it.
- R8: When `flag_wr` is high on a reference edge, `flag_wdata` = 0 clears `irq_flag` and `flag_wdata` = 1 has no effect. A hardware set in the same cycle wins over the clear.
- R9: At most one source of the switch is enabled at any time. After switchover, `sys_clk` follows `fb_clk`. Before it, `sys_clk` follows `ext_clk`.
- R10: Transitions of `ext_clk` spaced by fewer than `win_len` reference cycles never cause a switchover. In direct drive, `pll_locked` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock for all monitoring logic |
| por_n | input | 1 | Power-on reset, active low; the only reset of the flag and the lock synchronizer |
| rst_n | input | 1 | System reset, active low; configuration is sampled while low |
| cfg_pll_mode | input | 1 | Configuration pin: 1 = PLL, 0 = direct drive |
| wd_en | input | 1 | Monitoring enable; low disables failure detection |
| win_len | input | CNT_W | Reference cycles without an input transition that count as a failure |
| ext_clk | input | 1 | Monitored external clock, primary system clock source |
| fb_clk | input | 1 | Basic-frequency fallback clock |
| pll_locked | input | 1 | Lock indication of the external PLL |
| flag_wr | input | 1 | Software write strobe for the flag |
| flag_wdata | input | 1 | Write data; 0 clears the flag |
| sys_clk | output | 1 | Selected system clock |
| clk_sel | output | 1 | 1 once the fallback has been selected |
| irq_flag | output | 1 | Shared interrupt request flag |

## Verification
The assertions check several properties on every reference cycle:
- the two switch enables are never both set;
- the configuration stays fixed after reset;
- the fallback selection is sticky;
- every detected failure becomes a selection;
- any hardware set reaches the flag and beats a clear;
- a disabled monitor stays silent.

Other behaviour can only be shown by the bench scenarios, which drive clocks at several rates:
- whether a real gap in `ext_clk` is actually detected;
- that a slow but running clock is still caught;
- that `sys_clk` really carries fallback edges afterwards;
- that a lock loss during reset reaches the flag.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int CFM_CNT_W = 8;

  // Window reached: a zero window never fires.
  function automatic logic window_hit(input logic [31:0] cnt, input logic [31:0] win);
    return (win != 32'd0) && (cnt >= win);
  endfunction

  // Gap counter step: restart on a transition, saturate at the window.
  function automatic logic [31:0] gap_next(input logic [31:0] cnt, input logic [31:0] win,
                                           input logic seen);
    if (seen) return 32'd0;
    if (cnt >= win) return cnt;
    return cnt + 32'd1;
  endfunction
endpackage

// File: rtl/cfm_edge_mon.sv
module cfm_edge_mon #(
  parameter int CNT_W = cfm_pkg::CFM_CNT_W,
  parameter int SYNC_N = 3
) (
  input  logic             ref_clk,
  input  logic             rst_n,
  input  logic             mon_on_pin,
  input  logic             pll_cfg,
  input  logic [CNT_W-1:0] win_len,
  input  logic             ext_clk,
  output logic             gap_fail
);
  import cfm_pkg::*;

  logic [SYNC_N-1:0] ext_sync;
  logic [1:0]        en_sync;
  logic [CNT_W-1:0]  gap_cnt;
  logic              edge_seen;
  logic              mon_active;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sync <= '0;
      en_sync  <= '0;
    end else begin
      ext_sync <= {ext_sync[SYNC_N-2:0], ext_clk};
      en_sync  <= {en_sync[0], mon_on_pin};
    end
  end

  assign edge_seen  = ext_sync[SYNC_N-1] ^ ext_sync[SYNC_N-2];
  assign mon_active = en_sync[1] & ~pll_cfg;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)           gap_cnt <= '0;
    else if (!mon_active) gap_cnt <= '0;
    else                  gap_cnt <= CNT_W'(gap_next(32'(gap_cnt), 32'(win_len), edge_seen));
  end

  assign gap_fail = mon_active & window_hit(32'(gap_cnt), 32'(win_len));

  // R3: a monitor that is off reports no failure on the next cycle
  a_r3_off_silent: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_active |=> !gap_fail);
endmodule

// File: rtl/cfm_glitchless_mux.sv
module cfm_glitchless_mux (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic pick_b,
  output logic en_a,
  output logic en_b,
  output logic clk_out
);
  logic [1:0] a_sync;
  logic [1:0] b_sync;
  logic       a_clr_n;

  // Source A may be dead: its enable is dropped asynchronously once B is picked.
  assign a_clr_n = rst_n & ~pick_b;

  always_ff @(negedge clk_a or negedge a_clr_n) begin
    if (!a_clr_n) a_sync <= '0;
    else          a_sync <= {a_sync[0], ~pick_b & ~b_sync[1]};
  end

  always_ff @(negedge clk_b or negedge rst_n) begin
    if (!rst_n) b_sync <= '0;
    else        b_sync <= {b_sync[0], pick_b & ~a_sync[1]};
  end

  assign en_a    = a_sync[1];
  assign en_b    = b_sync[1];
  assign clk_out = (clk_a & en_a) | (clk_b & en_b);
endmodule

// File: rtl/cfm_irq_flag.sv
module cfm_irq_flag (
  input  logic ref_clk,
  input  logic por_n,
  input  logic pll_cfg,
  input  logic pll_locked,
  input  logic fail_set,
  input  logic flag_wr,
  input  logic flag_wdata,
  output logic irq_flag
);
  logic [2:0] lock_sync;
  logic       lock_lost;
  logic       set_evt;
  logic       sw_clear;

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n) lock_sync <= '0;
    else        lock_sync <= {lock_sync[1:0], pll_locked};
  end

  assign lock_lost = lock_sync[2] & ~lock_sync[1];
  assign set_evt   = fail_set | (pll_cfg & lock_lost);
  assign sw_clear  = flag_wr & ~flag_wdata;

  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n)        irq_flag <= 1'b0;
    else if (set_evt)  irq_flag <= 1'b1;
    else if (sw_clear) irq_flag <= 1'b0;
  end

  // R5 R6 R7: every hardware set reaches the flag, also against a clear (R8)
  a_r8_set_wins: assert property (@(posedge ref_clk) disable iff (!por_n)
    set_evt |=> irq_flag);
  // R8: a clear with no set empties the flag
  a_r8_clear: assert property (@(posedge ref_clk) disable iff (!por_n)
    (sw_clear && !set_evt) |=> !irq_flag);
endmodule

// File: rtl/clk_fail_guard.sv
module clk_fail_guard #(
  parameter int CNT_W = cfm_pkg::CFM_CNT_W
) (
  input  logic             ref_clk,
  input  logic             por_n,
  input  logic             rst_n,
  input  logic             cfg_pll_mode,
  input  logic             wd_en,
  input  logic [CNT_W-1:0] win_len,
  input  logic             ext_clk,
  input  logic             fb_clk,
  input  logic             pll_locked,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  output logic             sys_clk,
  output logic             clk_sel,
  output logic             irq_flag
);
  logic pll_cfg;
  logic gap_fail;
  logic fail_first;
  logic en_ext;
  logic en_fb;

  // Configuration follows the pin during reset and freezes afterwards.
  always_ff @(posedge ref_clk or negedge por_n) begin
    if (!por_n)      pll_cfg <= 1'b0;
    else if (!rst_n) pll_cfg <= cfg_pll_mode;
  end

  cfm_edge_mon #(.CNT_W(CNT_W)) u_mon (
    .ref_clk    (ref_clk),
    .rst_n      (rst_n),
    .mon_on_pin (wd_en),
    .pll_cfg    (pll_cfg),
    .win_len    (win_len),
    .ext_clk    (ext_clk),
    .gap_fail   (gap_fail)
  );

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)        clk_sel <= 1'b0;
    else if (gap_fail) clk_sel <= 1'b1;
  end

  assign fail_first = gap_fail & ~clk_sel;

  cfm_glitchless_mux u_mux (
    .clk_a   (ext_clk),
    .clk_b   (fb_clk),
    .rst_n   (rst_n),
    .pick_b  (clk_sel),
    .en_a    (en_ext),
    .en_b    (en_fb),
    .clk_out (sys_clk)
  );

  cfm_irq_flag u_flag (
    .ref_clk    (ref_clk),
    .por_n      (por_n),
    .pll_cfg    (pll_cfg),
    .pll_locked (pll_locked),
    .fail_set   (fail_first),
    .flag_wr    (flag_wr),
    .flag_wdata (flag_wdata),
    .irq_flag   (irq_flag)
  );

  a_r1_cfg_frozen: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(pll_cfg));
  a_r2_fail_selects: assert property (@(posedge ref_clk) disable iff (!rst_n)
    gap_fail |=> clk_sel);
  a_r4_sel_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
    clk_sel |=> clk_sel);
  a_r9_one_source: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !(en_ext && en_fb));
endmodule

// File: tb/tb_clk_fail_guard.sv
`timescale 1ns/1ps
module tb_clk_fail_guard;
  localparam int CNT_W = 8;

  logic ref_clk = 1'b0, fb_clk = 1'b0, ext_clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, cfg_pll_mode = 1'b0, wd_en = 1'b1;
  logic pll_locked = 1'b1, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic [CNT_W-1:0] win_len = 8'd16;
  logic sys_clk, clk_sel, irq_flag;
  int ext_half = 20;
  int checks = 0, errors = 0, sys_edges = 0;
  bit done = 0;

  always #4 ref_clk = ~ref_clk;
  always #10 fb_clk = ~fb_clk;
  initial forever begin
    if (ext_half == 0) #4;
    else begin #(ext_half) ext_clk = ~ext_clk; end
  end
  always @(posedge sys_clk) sys_edges++;

  clk_fail_guard #(.CNT_W(CNT_W)) dut (.*);

  typedef struct packed {
    logic pll; logic wden; int half; logic drop; logic esel; logic eflag;
  } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b1, 20,  1'b0, 1'b0, 1'b0},  // R10 fast clock
    '{1'b0, 1'b1, 0,   1'b0, 1'b1, 1'b1},  // R2 R5 stopped
    '{1'b0, 1'b0, 0,   1'b0, 1'b0, 1'b0},  // R3 disabled
    '{1'b0, 1'b1, 300, 1'b0, 1'b1, 1'b1},  // R2 too slow
    '{1'b0, 1'b1, 40,  1'b0, 1'b0, 1'b0},  // R10 gap 5 cycles
    '{1'b1, 1'b1, 0,   1'b1, 1'b0, 1'b1},  // R6 lock loss, no switch
    '{1'b1, 1'b1, 20,  1'b0, 1'b0, 1'b0},  // R6 locked
    '{1'b0, 1'b1, 20,  1'b1, 1'b0, 1'b0}   // R10 lock ignored in direct
  };

  task automatic wait_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic start(input logic pll, input logic en, input int half);
    por_n = 0; rst_n = 0; cfg_pll_mode = pll; wd_en = en;
    pll_locked = 1; ext_half = half; flag_wr = 0;
    wait_ref(4); por_n = 1; wait_ref(4); rst_n = 1; wait_ref(10);
  endtask

  task automatic write_flag(input logic d);
    flag_wr = 1; flag_wdata = d; wait_ref(1); flag_wr = 0; wait_ref(2);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int e0;
    // reset state
    wait_ref(2);
    check("R4 reset clk_sel", clk_sel, 1'b0);
    check("R7 reset irq_flag", irq_flag, 1'b0);

    foreach (VECS[i]) begin
      start(VECS[i].pll, VECS[i].wden, VECS[i].half);
      if (VECS[i].drop) pll_locked = 0;
      wait_ref(120);
      check($sformatf("R2/R3/R6/R10 vec%0d clk_sel", i), clk_sel, VECS[i].esel);
      check($sformatf("R5/R6 vec%0d irq_flag", i), irq_flag, VECS[i].eflag);
    end

    // R7: lock loss while system reset held
    por_n = 0; rst_n = 0; cfg_pll_mode = 1; pll_locked = 1;
    wait_ref(4); por_n = 1; wait_ref(6);
    pll_locked = 0; wait_ref(10);
    check("R7 flag set in reset", irq_flag, 1'b1);
    check("R7 rst_n still low", rst_n, 1'b0);

    // R8: write 1 ignored, write 0 clears
    write_flag(1'b1);
    check("R8 write 1 no effect", irq_flag, 1'b1);
    write_flag(1'b0);
    check("R8 write 0 clears", irq_flag, 1'b0);

    // R9: sys_clk follows ext before, fb after
    start(1'b0, 1'b1, 20);
    e0 = sys_edges; wait_ref(50);
    check("R9 ext edges", (sys_edges - e0) >= 8 && (sys_edges - e0) <= 12, 1'b1);
    ext_half = 0; wait_ref(60);
    check("R2 switched", clk_sel, 1'b1);
    e0 = sys_edges; wait_ref(50);
    check("R9 fb edges", (sys_edges - e0) >= 17, 1'b1);

    // R4: sticky despite clock resuming, cleared by reset
    ext_half = 20; wait_ref(100);
    check("R4 sticky", clk_sel, 1'b1);
    rst_n = 0; wait_ref(3);
    check("R4 reset clears sel", clk_sel, 1'b0);
    rst_n = 1; wait_ref(50);
    check("R4 ext kept after reset", clk_sel, 1'b0);

    // R8: clear works while the failed clock stays dead
    ext_half = 0; wait_ref(60);
    check("R5 flag on fail", irq_flag, 1'b1);
    write_flag(1'b0);
    check("R8 clear after fail", irq_flag, 1'b0);

    // R1: pin change after reset ignored
    start(1'b0, 1'b1, 20);
    cfg_pll_mode = 1; wait_ref(10);
    ext_half = 0; wait_ref(60);
    check("R1 stays direct drive", clk_sel, 1'b1);

    // R3: disabling after start prevents detection
    start(1'b0, 1'b1, 20);
    wd_en = 0; wait_ref(6); ext_half = 0; wait_ref(80);
    check("R3 disabled late", clk_sel, 1'b0);

    finish_run();
  end
endmodule